// File: doc/BRIEF.md
# Column-Parity Flit Stream Encoder

This block sits on the transmit side of an on-chip link and protects a stream of flits. Each data flit of `DATA_W` bits leaves with one extra bit, the even parity of its data bits, so the receiver can spot a single flipped bit per flit. The block also folds every encoded flit of a group into a running column parity. At the end of a group of M flits, it can place that column parity on the stream as an extra flit. The receiver then uses it together with the per-flit parity bits to locate a bad bit by row and column.

The extra flit is issued adaptively. With `issue_all` high every group is closed by its parity flit. With `issue_all` low the parity flit is dropped, and the stream costs only one bit per flit, unless the receiver has pulsed `pf_req` while that group was open. The group size comes from `grp_size` and is taken once per group. A sideband bit, `out_is_pf`, tells the receiver which output flit is the column parity.

Both streams use valid/ready. A data flit passes through in the same cycle it is offered: `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. While a parity flit is being offered, `in_ready` is held low and the parity flit stays on the output until `out_ready` accepts it. A flit counts toward its group only on an input handshake, so back-pressure stalls the group counter and the column parity with it.

Top module: `colpar_flit_encoder`

## Requirements
- R1: Every data flit leaves with `out_data[DATA_W-1:0]` equal to the input data, `out_data[DATA_W]` equal to the XOR of those data bits, and `out_is_pf` low.
- R2: A parity flit carries in all `DATA_W+1` bits the XOR of the encoded flits of its own group only, with `out_is_pf` high. The column parity restarts from the first flit of each group.
- R3: With `issue_all` high, exactly one parity flit follows the handshake of every M-th flit of a group, before any further data flit.
- R4: With `issue_all` low and no request, no parity flit appears and the output is the data flits alone.
- R5: A `pf_req` pulse seen while a group is open, up to and including the cycle its last flit is accepted, makes that group end with a parity flit. The request is used up by that group, and later groups go without one.
- R6: `grp_size` is sampled when the first flit of a group is accepted. A change while the group is open takes effect only at the next group.
- R7: A `grp_size` of 0 is treated as 1, and a value above `MAX_GRP` is treated as `MAX_GRP`.
- R8: While a data flit is offered, `in_ready` equals `out_ready`. While a parity flit is offered, `in_ready` is low, and the parity flit and `out_is_pf` hold until `out_ready` is high. The encoded stream does not depend on the back-pressure pattern.
- R9: After reset no parity flit is pending and no group is open. With `in_valid` low, `out_valid` and `out_is_pf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_size | input | GRP_W | Flits per group (M), sampled at a group's first flit |
| issue_all | input | 1 | High: always append the parity flit |
| pf_req | input | 1 | Receiver request for the current group's parity flit |
| in_valid | input | 1 | Input flit valid |
| in_ready | output | 1 | Input flit accepted when high with in_valid |
| in_data | input | DATA_W | Input data flit |
| out_valid | output | 1 | Output flit valid |
| out_ready | input | 1 | Downstream accepts the output flit |
| out_data | output | DATA_W+1 | Encoded flit: parity bit on top of data |
| out_is_pf | output | 1 | High when the output flit is the column parity |

## Verification
The encoder is driven with distinct flit patterns across several group sizes: 4 with forced issue, 3 changing to 2 in the middle of a group, and the clamped values 0 and 20. The whole output stream, including parity values, is compared against a model, so a wrong group boundary, a stale column parity or a wrong parity bit each show up as a mismatch at a known position. Adaptive runs with and without a request separate dropping the parity flit from issuing it once for exactly one group. A back-pressured run is compared with the same expected stream, which shows that stalls neither count phantom flits nor lose the held parity flit.

// File: rtl/colpar_pkg.sv
package colpar_pkg;
  typedef enum logic {
    EMIT_DATA = 1'b0,
    EMIT_PAR  = 1'b1
  } emit_st_e;
endpackage

// File: rtl/colpar_row_enc.sv
module colpar_row_enc #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W:0]   code
);
  // even parity on top of the data bits
  assign code = {^data, data};
endmodule

// File: rtl/colpar_col_acc.sv
module colpar_col_acc #(
  parameter int CODE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (take)  acc <= first ? code : (acc ^ code);
  end
endmodule

// File: rtl/colpar_grp_ctrl.sv
module colpar_grp_ctrl
  import colpar_pkg::*;
#(
  parameter int MAX_GRP = 16,
  parameter int GRP_W   = $clog2(MAX_GRP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] grp_size,
  input  logic             issue_all,
  input  logic             pf_req,
  input  logic             take,
  input  logic             pf_done,
  output logic             first,
  output logic             par_state
);
  emit_st_e         st;
  logic [GRP_W-1:0] cnt, cnt_nx, m_q, m_live, m_cur;
  logic             req_q, last, issue;

  assign m_live = (grp_size == '0) ? GRP_W'(1) :
                  (grp_size > GRP_W'(MAX_GRP)) ? GRP_W'(MAX_GRP) : grp_size;
  assign first     = (cnt == '0);
  assign m_cur     = first ? m_live : m_q;
  assign cnt_nx    = cnt + GRP_W'(1);
  assign last      = (cnt_nx == m_cur);
  assign issue     = issue_all | req_q | pf_req;
  assign par_state = (st == EMIT_PAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      m_q   <= GRP_W'(1);
      req_q <= 1'b0;
      st    <= EMIT_DATA;
    end else begin
      if (take) begin
        if (first) m_q <= m_live;
        if (last) begin
          cnt   <= '0;
          req_q <= 1'b0;
          if (issue) st <= EMIT_PAR;
        end else begin
          cnt <= cnt_nx;
          if (pf_req) req_q <= 1'b1;
        end
      end else if (pf_req) begin
        req_q <= 1'b1;
      end
      if (st == EMIT_PAR && pf_done) st <= EMIT_DATA;
    end
  end

  // R6
  grp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt < m_q));

  // R6
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && $past(cnt != '0) |-> $stable(m_q));

  // R8
  par_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == EMIT_PAR) |-> !take);

  // R3
  par_at_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == EMIT_PAR) |-> (cnt == '0));
endmodule

// File: rtl/colpar_flit_encoder.sv
module colpar_flit_encoder #(
  parameter int DATA_W  = 8,
  parameter int MAX_GRP = 16,
  parameter int GRP_W   = $clog2(MAX_GRP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_W-1:0]  grp_size,
  input  logic              issue_all,
  input  logic              pf_req,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W:0]   out_data,
  output logic              out_is_pf
);
  localparam int CODE_W = DATA_W + 1;

  logic [CODE_W-1:0] code, acc;
  logic              take, first, par_state, pf_done;

  colpar_row_enc #(.DATA_W(DATA_W)) u_row (
    .data (in_data),
    .code (code)
  );

  colpar_grp_ctrl #(.MAX_GRP(MAX_GRP), .GRP_W(GRP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_size  (grp_size),
    .issue_all (issue_all),
    .pf_req    (pf_req),
    .take      (take),
    .pf_done   (pf_done),
    .first     (first),
    .par_state (par_state)
  );

  colpar_col_acc #(.CODE_W(CODE_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .first (first),
    .code  (code),
    .acc   (acc)
  );

  assign in_ready  = par_state ? 1'b0 : out_ready;
  assign out_valid = par_state ? 1'b1 : in_valid;
  assign out_data  = par_state ? acc : code;
  assign out_is_pf = par_state;
  assign take      = in_valid & in_ready;
  assign pf_done   = par_state & out_ready;

  // R1
  data_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_pf |-> (^out_data) == 1'b0);

  // R8
  pf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_pf && !out_ready |=> out_valid && out_is_pf && $stable(out_data));

  // R8
  pf_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_pf |-> !in_ready);

  // R4
  pf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_pf && !$past(out_is_pf) |-> $past(in_valid && in_ready));
endmodule

// File: tb/test_colpar_flit_encoder.sv
`timescale 1ns/1ps
module test_colpar_flit_encoder;
  localparam int DW = 8;
  localparam int MG = 16;
  localparam int GW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [GW-1:0] grp_size = GW'(4);
  logic          issue_all = 1'b0, pf_req = 1'b0;
  logic          in_valid = 1'b0, in_ready;
  logic [DW-1:0] in_data = '0;
  logic          out_valid, out_ready = 1'b1, out_is_pf;
  logic [DW:0]   out_data;

  colpar_flit_encoder #(.DATA_W(DW), .MAX_GRP(MG), .GRP_W(GW)) i_colpar_flit_encoder (
    .clk(clk), .rst_n(rst_n), .grp_size(grp_size), .issue_all(issue_all),
    .pf_req(pf_req), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_pf(out_is_pf)
  );

  always #2.5 clk = ~clk;

  int n_run = 0, n_bad = 0, ocnt = 0, ecnt = 0, viol = 0, bp_cnt = 0;
  bit bp_en = 1'b0, done = 1'b0;
  logic [DW+1:0] obuf [0:255];
  logic [DW+1:0] ebuf [0:255];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dat(int i, int seed);
    return DW'(i * 53 + 29) ^ DW'(seed);
  endfunction

  function automatic int clampm(int v);
    if (v == 0) return 1;
    if (v > MG) return MG;
    return v;
  endfunction

  // output monitor and handshake rules (R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready && ocnt < 256) begin
        obuf[ocnt] = {out_is_pf, out_data};
        ocnt++;
      end
      if (out_is_pf && in_ready) viol++;
      if (!out_is_pf && in_ready != out_ready) viol++;
    end
  end

  always @(posedge clk) begin
    #1;
    bp_cnt++;
    out_ready = !bp_en || (bp_cnt % 3 != 0);
  end

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; pf_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    ocnt = 0; viol = 0;
    rst_n = 1'b1;
  endtask

  task automatic run(string req, int nfl, int m1, int m2, int chg, bit all,
                     int req_at, bit bp, int seed);
    int cnt = 0, curm = 1;
    bit rq = 1'b0;
    logic [DW:0] acc = '0, enc;
    do_reset();
    issue_all = all; bp_en = bp;
    ecnt = 0;
    for (int i = 0; i < nfl; i++) begin
      enc = {^dat(i, seed), dat(i, seed)};
      if (cnt == 0) begin curm = clampm((i > chg) ? m2 : m1); acc = enc; end
      else acc = acc ^ enc;
      ebuf[ecnt] = {1'b0, enc}; ecnt++;
      if (i == req_at) rq = 1'b1;
      if (cnt + 1 == curm) begin
        if (all || rq) begin ebuf[ecnt] = {1'b1, acc}; ecnt++; end
        rq = 1'b0; cnt = 0;
      end else cnt++;
    end
    for (int i = 0; i < nfl; i++) begin
      bit h;
      grp_size = GW'((i > chg) ? m2 : m1);
      in_data = dat(i, seed); in_valid = 1'b1; pf_req = (i == req_at);
      forever begin
        @(negedge clk); h = in_ready;
        @(posedge clk); #1; pf_req = 1'b0;
        if (h) break;
      end
    end
    in_valid = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    bp_en = 1'b0;
    chk(ocnt == ecnt, req, "output flit count", ocnt, ecnt);
    for (int k = 0; k < ecnt && k < ocnt; k++)
      chk(obuf[k] === ebuf[k], req, $sformatf("flit %0d {pf,data}", k),
          int'(obuf[k]), int'(ebuf[k]));
    chk(viol == 0, req, "ready/valid rule violations", viol, 0);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    chk(out_is_pf == 1'b0, "R9", "out_is_pf after reset", out_is_pf, 0);
    chk(in_ready == out_ready, "R9", "in_ready after reset", in_ready, out_ready);
  endtask

  // R1 R2 R3: forced issue, groups of 4
  task automatic t_always();   run("R1 R2 R3", 12, 4, 4, 99, 1'b1, -1, 1'b0, 8'h00); endtask
  // R4: adaptive, no request
  task automatic t_quiet();    run("R4", 8, 4, 4, 99, 1'b0, -1, 1'b0, 8'h5a); endtask
  // R5: request inside second group only
  task automatic t_request();  run("R5", 12, 4, 4, 99, 1'b0, 5, 1'b0, 8'hc3); endtask
  // R5: request on the closing flit of the first group
  task automatic t_req_last(); run("R5", 8, 4, 4, 99, 1'b0, 3, 1'b0, 8'h27); endtask
  // R6: size 3 changes to 2 after the first flit
  task automatic t_resize();   run("R6", 7, 3, 2, 0, 1'b1, -1, 1'b0, 8'h91); endtask
  // R7: size 0 acts as 1, size 20 acts as 16
  task automatic t_clamp_lo(); run("R7", 5, 0, 0, 99, 1'b1, -1, 1'b0, 8'h3c); endtask
  task automatic t_clamp_hi(); run("R7", 20, 20, 20, 99, 1'b1, -1, 1'b0, 8'he1); endtask
  // R8: back-pressure does not change the stream
  task automatic t_backpr();   run("R8", 12, 3, 3, 99, 1'b1, -1, 1'b1, 8'h66); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_always();
    t_quiet();
    t_request();
    t_req_last();
    t_resize();
    t_clamp_lo();
    t_clamp_hi();
    t_backpr();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule